// File: doc/BRIEF.md
# Command Status Block Composer

This block assembles the reply that a disk command sequencer hands back to the host when a command finishes or is rejected. The sequencer presents one build request. It carries a command code, a device code, a result kind and the block address that follows the last one processed. The block then fills a small buffer of 16-bit words. Word 0 is a header. After it come the error and progress words that the result kind calls for. The block raises a status-out-full flag while unread words remain.

The host drains the reply through a single word-read register. Each read strobe moves the next word onto the read-data output. When the final word has been taken, the block drops the full flag and forgets the length. An interrupt request is posted with each build. Failures always post one. Successful completions post one only when the sequencer says so.

Top module: `status_block_unit`

## Requirements
- R1: After reset, rd_data is 0 and out_full, overrun and irq_req are all low.
- R2: Word 0 of every block is the header. Bits 4:0 hold the command code, bits 7:5 hold the device code (7 is the adapter) and bits 15:8 hold the block length in words.
- R3: Result kind 1 (unsupported command) gives 9 words. Word 1 is 0x0F03, word 2 is 0x0002 and words 3 to 8 are 0.
- R4: Result kind 2 (drive missing) gives 9 words. Word 1 is 0x0C11, word 2 is 0x000B and words 3 to 8 are 0.
- R5: Result kind 3 (address out of range) gives 9 words. Word 1 is 0x0E01, word 2 is 0x0007 and words 3 to 8 are 0.
- R6: Result kind 0 (success) gives 7 words: 0, 0x1900, 0, then the low 16 bits of (bld_addr − 1), then bits 31:16 of (bld_addr − 1) taken modulo 2^ADDR_W and zero-filled, then 0. Address 0 wraps to all ones.
- R7: A build raises out_full on the next cycle. In that same cycle, a failure kind pulses irq_req for one cycle with irq_code = device code in bits 7:5 and 0xC in bits 3:0. A success pulses irq_req only if bld_post_ok was high, and then with 0x1 in bits 3:0.
- R8: Each rd_en while words remain places the next word on rd_data in the following cycle. The read that takes the last word also clears out_full.
- R9: An rd_en with no words remaining returns 0 on rd_data and changes no other output.
- R10: A build while out_full is high replaces the unread block, which restarts from word 0, and sets overrun. Overrun stays high until reset.
- R11: When a build and a read come in the same cycle, the build wins. rd_data becomes 0 and the new block starts from word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bld_valid | input | 1 | Build request for one cycle |
| bld_kind | input | 2 | Result kind: 0 success, 1 unsupported, 2 drive missing, 3 out of range |
| bld_cmd | input | 5 | Command code placed in the header |
| bld_dev | input | 3 | Device code (7 = adapter) |
| bld_addr | input | ADDR_W | Address after the last block processed |
| bld_post_ok | input | 1 | Sequencer's decision to interrupt on success |
| rd_en | input | 1 | Host word-read strobe |
| rd_data | output | 16 | Word returned by the last read |
| out_full | output | 1 | Unread status words remain |
| overrun | output | 1 | Sticky: a block was replaced before it was drained |
| irq_req | output | 1 | One-cycle interrupt post |
| irq_code | output | 8 | Interrupt code of the last build |

## Verification
The bench builds the block with ADDR_W = 20 and DEPTH = 9. The narrow address makes the upper address word small and nonzero, and it lets the wrap of address 0 produce the value 0x000F, so both address words can be predicted exactly. A depth of 9 is the smallest that holds a failure block. This means every failure reply fills the buffer to its last entry, and the read that empties the buffer is always the same read that lands on the highest index.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int WORD_W   = 16;
  localparam int CMD_W    = 5;
  localparam int DEV_W    = 3;
  localparam int FAIL_LEN = 9;
  localparam int OK_LEN   = 7;

  typedef enum logic [1:0] {
    RES_OK    = 2'd0,
    RES_UNSUP = 2'd1,
    RES_NODEV = 2'd2,
    RES_RANGE = 2'd3
  } res_kind_t;

  localparam logic [3:0] IRQ_NIB_OK   = 4'h1;
  localparam logic [3:0] IRQ_NIB_FAIL = 4'hC;
  localparam logic [WORD_W-1:0] DEV_STATUS_OK = 16'h1900;
endpackage

// File: rtl/sb_word_gen.sv
module sb_word_gen
  import sb_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int DEPTH  = 9,
  parameter int LEN_W  = $clog2(DEPTH + 1)
) (
  input  logic [1:0]        kind,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [DEV_W-1:0]  dev,
  input  logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] words [DEPTH],
  output logic [LEN_W-1:0]  len
);
  logic [ADDR_W-1:0] am1;
  logic [WORD_W-1:0] code_a;
  logic [WORD_W-1:0] code_b;
  logic              is_ok;

  always_comb begin
    am1   = addr - 1'b1;
    is_ok = (res_kind_t'(kind) == RES_OK);
    unique case (res_kind_t'(kind))
      RES_UNSUP: begin code_a = 16'h0F03; code_b = 16'h0002; end
      RES_NODEV: begin code_a = 16'h0C11; code_b = 16'h000B; end
      RES_RANGE: begin code_a = 16'h0E01; code_b = 16'h0007; end
      default:   begin code_a = 16'h0000; code_b = DEV_STATUS_OK; end
    endcase
    len = is_ok ? LEN_W'(OK_LEN) : LEN_W'(FAIL_LEN);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    if (i == 0) begin : g_hdr
      assign words[i] = {8'(len), dev, cmd};
    end else if (i == 1) begin : g_err
      assign words[i] = code_a;
    end else if (i == 2) begin : g_stat
      assign words[i] = code_b;
    end else if (i == 4) begin : g_alo
      assign words[i] = is_ok ? am1[15:0] : '0;
    end else if (i == 5) begin : g_ahi
      assign words[i] = is_ok ? WORD_W'(am1 >> 16) : '0;
    end else begin : g_zero
      assign words[i] = '0;
    end
  end
endmodule

// File: rtl/sb_readout.sv
module sb_readout
  import sb_pkg::*;
#(
  parameter int DEPTH = 9,
  parameter int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] new_words [DEPTH],
  input  logic [LEN_W-1:0]  new_len,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic              out_full,
  output logic              overrun
);
  logic [WORD_W-1:0] buf_q [DEPTH];
  logic [LEN_W-1:0]  ptr_q, ptr_n;
  logic [LEN_W-1:0]  len_q, len_n;
  logic              full_q, full_n;
  logic              ovr_q, ovr_n;
  logic [WORD_W-1:0] rdd_q, rdd_n;
  logic              rdd_en;
  logic [LEN_W-1:0]  ptr_inc;

  always_comb begin
    ptr_n   = ptr_q;
    len_n   = len_q;
    full_n  = full_q;
    ovr_n   = ovr_q;
    rdd_n   = rdd_q;
    rdd_en  = 1'b0;
    ptr_inc = ptr_q + 1'b1;
    if (load) begin
      ptr_n  = '0;
      len_n  = new_len;
      full_n = 1'b1;
      ovr_n  = ovr_q | full_q;
      if (rd_en) begin
        rdd_en = 1'b1;
        rdd_n  = '0;
      end
    end else if (rd_en) begin
      rdd_en = 1'b1;
      if (full_q) begin
        rdd_n = buf_q[ptr_q];
        if (ptr_inc == len_q) begin
          ptr_n  = '0;
          len_n  = '0;
          full_n = 1'b0;
        end else begin
          ptr_n = ptr_inc;
        end
      end else begin
        rdd_n = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      len_q  <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      rdd_q  <= '0;
    end else begin
      ptr_q  <= ptr_n;
      len_q  <= len_n;
      full_q <= full_n;
      ovr_q  <= ovr_n;
      if (rdd_en) rdd_q <= rdd_n;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_buf
    always_ff @(posedge clk) begin
      if (load) buf_q[i] <= new_words[i];
    end
  end

  assign rd_data  = rdd_q;
  assign out_full = full_q;
  assign overrun  = ovr_q;
endmodule

// File: rtl/sb_irq_post.sv
module sb_irq_post
  import sb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [1:0]       kind,
  input  logic [DEV_W-1:0] dev,
  input  logic             post_ok,
  output logic             irq_req,
  output logic [7:0]       irq_code
);
  logic       req_q, req_n;
  logic [7:0] code_q, code_n;
  logic       fail;

  always_comb begin
    fail   = (res_kind_t'(kind) != RES_OK);
    req_n  = load && (fail || post_ok);
    code_n = code_q;
    if (load) code_n = {dev, 1'b0, fail ? IRQ_NIB_FAIL : IRQ_NIB_OK};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      code_q <= '0;
    end else begin
      req_q  <= req_n;
      code_q <= code_n;
    end
  end

  assign irq_req  = req_q;
  assign irq_code = code_q;
endmodule

// File: rtl/status_block_unit.sv
module status_block_unit
  import sb_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int DEPTH  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bld_valid,
  input  logic [1:0]        bld_kind,
  input  logic [CMD_W-1:0]  bld_cmd,
  input  logic [DEV_W-1:0]  bld_dev,
  input  logic [ADDR_W-1:0] bld_addr,
  input  logic              bld_post_ok,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic              out_full,
  output logic              overrun,
  output logic              irq_req,
  output logic [7:0]        irq_code
);
  localparam int LEN_W = $clog2(DEPTH + 1);

  logic              rs1_q, rs2_q;
  logic              rst_core_n;
  logic [WORD_W-1:0] gen_words [DEPTH];
  logic [LEN_W-1:0]  gen_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_core_n = rs2_q;

  sb_word_gen #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .LEN_W(LEN_W)) u_gen (
    .kind  (bld_kind),
    .cmd   (bld_cmd),
    .dev   (bld_dev),
    .addr  (bld_addr),
    .words (gen_words),
    .len   (gen_len)
  );

  sb_readout #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .load      (bld_valid),
    .new_words (gen_words),
    .new_len   (gen_len),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .out_full  (out_full),
    .overrun   (overrun)
  );

  sb_irq_post u_irq (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load     (bld_valid),
    .kind     (bld_kind),
    .dev      (bld_dev),
    .post_ok  (bld_post_ok),
    .irq_req  (irq_req),
    .irq_code (irq_code)
  );
endmodule

// File: rtl/sb_checker.sv
module sb_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        bld_valid,
  input logic [1:0]  bld_kind,
  input logic        rd_en,
  input logic [15:0] rd_data,
  input logic        out_full,
  input logic        overrun,
  input logic        irq_req,
  input logic [7:0]  irq_code
);
  a_r7_full_after_build: assert property (@(posedge clk) disable iff (!rst_n)
    bld_valid |=> out_full);
  a_r7_fail_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (bld_valid && bld_kind != 2'd0) |=> (irq_req && irq_code[3:0] == 4'hC));
  a_r7_irq_from_build: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> $past(bld_valid));
  a_r8_full_falls_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_full) |-> $past(rd_en));
  a_r9_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !out_full && !bld_valid) |=> (rd_data == 16'h0 && !out_full));
  a_r10_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (bld_valid && out_full) |=> overrun);
  a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  a_r11_build_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (bld_valid && rd_en) |=> (rd_data == 16'h0));
endmodule

bind status_block_unit sb_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .bld_valid (bld_valid),
  .bld_kind  (bld_kind),
  .rd_en     (rd_en),
  .rd_data   (rd_data),
  .out_full  (out_full),
  .overrun   (overrun),
  .irq_req   (irq_req),
  .irq_code  (irq_code)
);

// File: tb/sim_status_block_unit.sv
`timescale 1ns/1ps
module sim_status_block_unit;
  localparam int AW = 20;
  localparam int DP = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bld_valid = 1'b0;
  logic [1:0]    bld_kind = '0;
  logic [4:0]    bld_cmd = '0;
  logic [2:0]    bld_dev = '0;
  logic [AW-1:0] bld_addr = '0;
  logic          bld_post_ok = 1'b0;
  logic          rd_en = 1'b0;
  logic [15:0]   rd_data;
  logic          out_full, overrun, irq_req;
  logic [7:0]    irq_code;

  always #2 clk = ~clk;

  status_block_unit #(.ADDR_W(AW), .DEPTH(DP)) u0 (
    .clk(clk), .rst_n(rst_n), .bld_valid(bld_valid), .bld_kind(bld_kind),
    .bld_cmd(bld_cmd), .bld_dev(bld_dev), .bld_addr(bld_addr),
    .bld_post_ok(bld_post_ok), .rd_en(rd_en), .rd_data(rd_data),
    .out_full(out_full), .overrun(overrun), .irq_req(irq_req),
    .irq_code(irq_code)
  );

  // Behavioural reference model
  int          q[$];
  int          rst_cnt = 0;
  logic [15:0] e_rd = '0;
  logic        e_full = 1'b0, e_ovr = 1'b0, e_irq = 1'b0;
  logic [7:0]  e_code = '0;
  int          checks = 0, failures = 0;
  string       cur_req = "R1";
  bit          done = 0;

  task automatic make_block(input int kind, input int cmd, input int dev, input int addr);
    int len, am1;
    q.delete();
    len = (kind == 0) ? 7 : 9;
    q.push_back(cmd + (dev * 32) + (len * 256));
    if (kind == 0) begin
      am1 = (addr - 1) & ((1 << AW) - 1);
      q.push_back(0); q.push_back('h1900); q.push_back(0);
      q.push_back(am1 & 'hFFFF); q.push_back(am1 >>> 16); q.push_back(0);
    end else begin
      case (kind)
        1: begin q.push_back('h0F03); q.push_back('h0002); end
        2: begin q.push_back('h0C11); q.push_back('h000B); end
        default: begin q.push_back('h0E01); q.push_back('h0007); end
      endcase
      for (int k = 0; k < 6; k++) q.push_back(0);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      rst_cnt = 0;
      q.delete();
      e_rd = '0; e_full = 0; e_ovr = 0; e_irq = 0; e_code = '0;
    end else if (rst_cnt < 2) begin
      rst_cnt++;
    end else begin
      e_irq = 0;
      if (bld_valid) begin
        if (e_full) e_ovr = 1;
        make_block(bld_kind, bld_cmd, bld_dev, bld_addr);
        e_full = 1;
        if (rd_en) e_rd = '0;
        e_irq = (bld_kind != 0) || bld_post_ok;
        e_code = {bld_dev, 1'b0, (bld_kind != 0) ? 4'hC : 4'h1};
      end else if (rd_en) begin
        if (q.size() > 0) begin
          e_rd = 16'(q.pop_front());
          if (q.size() == 0) e_full = 0;
        end else begin
          e_rd = '0;
        end
      end
    end
  end

  task automatic compare();
    checks++;
    if (rd_data !== e_rd || out_full !== e_full || overrun !== e_ovr ||
        irq_req !== e_irq || irq_code !== e_code) begin
      failures++;
      $display("FAIL %s: actual rd=%h full=%b ovr=%b irq=%b code=%h expected rd=%h full=%b ovr=%b irq=%b code=%h",
               cur_req, rd_data, out_full, overrun, irq_req, irq_code,
               e_rd, e_full, e_ovr, e_irq, e_code);
    end
  endtask

  task automatic step(input bit b, input int kind, input int cmd, input int dev,
                      input int addr, input bit post, input bit rd);
    bld_valid = b; bld_kind = 2'(kind); bld_cmd = 5'(cmd); bld_dev = 3'(dev);
    bld_addr = AW'(addr); bld_post_ok = post; rd_en = rd;
    @(negedge clk);
    compare();
    bld_valid = 0; rd_en = 0;
  endtask

  task automatic reads(input int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    for (int k = 0; k < 3; k++) begin @(negedge clk); compare(); end
    rst_n = 1;
    cur_req = "R1";
    for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 0, 0, 0);
    cur_req = "R3";
    step(1, 1, 'h0A, 7, 0, 0, 0);
    reads(9);
    cur_req = "R9";
    reads(2);
    step(0, 0, 0, 0, 0, 0, 0);
    cur_req = "R6";
    step(1, 0, 'h01, 0, 'h12345, 1, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    reads(7);
    cur_req = "R2";
    step(1, 0, 'h02, 1, 0, 0, 0);
    reads(7);
    cur_req = "R4";
    step(1, 2, 'h03, 1, 5, 0, 0);
    reads(9);
    cur_req = "R5";
    step(1, 3, 'h01, 0, 'hFFFFF, 1, 0);
    reads(9);
    cur_req = "R7";
    step(1, 0, 'h05, 6, 'h40, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    reads(7);
    cur_req = "R8";
    step(1, 0, 'h04, 0, 'hABCDE, 1, 0);
    reads(2);
    step(0, 0, 0, 0, 0, 0, 0);
    reads(5);
    cur_req = "R10";
    step(1, 1, 'h1F, 7, 0, 0, 0);
    reads(3);
    step(1, 2, 'h09, 1, 0, 0, 0);
    reads(9);
    cur_req = "R11";
    step(1, 3, 'h11, 2, 0, 0, 1);
    reads(9);
    step(1, 0, 'h01, 3, 'h10001, 1, 1);
    reads(8);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule